// File: doc/BRIEF.md
# Sample-Step Shift Selector

This block delays a stream that carries several samples side by side in every clock word. The delay is a whole number of samples, from zero up to one word less one sample. It sits behind a coarser stage that can only delay whole words. Together the two stages reach single-sample resolution, which is about 1 ns at the intended sample rate.

Each clock, the block keeps the word it received before the present one. Laid side by side, the two words form a window that is two words wide. The output word is a slice of that window, one word wide. A shift select picks where the slice starts, and each step of the select moves the slice back by one sample. The select comes from the delay control path. It travels down the pipe with the word it arrives with, so any change takes effect on a clean word boundary. No output word is ever built from two settings.

Top module: `sample_shift_selector`

## Requirements
- R1: While reset is low, and for the first two clocks after it is released, `dout_o` is all zero. Samples from before the first captured word count as zero.
- R2: Lane k of a word sits in bits [8k+7:8k], and lane 0 is the oldest sample in time. With the default of 4 lanes of 8 bits, sample n of the stream is lane n mod 4 of word n div 4.
- R3: With select 0, the output word equals the input word captured two clocks earlier.
- R4: With select 1, output lane 0 is lane 3 of the previous word, and output lanes 1 to 3 are lanes 0 to 2 of the current word.
- R5: With select 2, output lanes 0 and 1 are lanes 2 and 3 of the previous word, and output lanes 2 and 3 are lanes 0 and 1 of the current word.
- R6: With select 3, output lanes 0 to 2 are lanes 1 to 3 of the previous word, and output lane 3 is lane 0 of the current word.
- R7: A word and a select captured on clock edge n set the output seen from edge n+1 onward. The latency is two registers.
- R8: The select applies to the word it is captured with. When it rises between two words, samples are repeated at the boundary. When it falls, samples are skipped. Every output word is consistent with exactly one setting.
- R9: While the select holds a value d, the output sample stream equals the input sample stream delayed by d samples plus two words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din_i | input | LANES*SAMPLE_W (32) | Input word, lane 0 oldest, in the low byte |
| shift_sel_i | input | clog2(LANES) (2) | Sample shift applied to the word presented with it |
| dout_o | output | LANES*SAMPLE_W (32) | Shifted output word |

## Verification
Two functions can fall in the same cycle: a change of the select, and a slice that draws samples from two different input words. The bench provokes this by changing the select on every word through all four values in a mixed order, with random data. A reference model built on a flat sample queue checks each output word. It indexes every output sample from the select of that word alone, so any lane that used the old or the next setting, or the wrong input word, shows up as a miscompare. The selector itself also checks each fixed shift against the past input words.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

  localparam int unsigned SSEL_LANES_DEF  = 4;
  localparam int unsigned SSEL_SAMPLE_DEF = 8;

  // Position inside the two-word window (previous word occupies the lower
  // half) that feeds output lane 'lane' when the stream is shifted by 'shift'.
  function automatic int window_src(int lanes, int lane, int shift);
    return lanes + lane - shift;
  endfunction

endpackage

// File: rtl/ssel_history.sv
module ssel_history #(
  parameter  int unsigned LANES    = ssel_pkg::SSEL_LANES_DEF,
  parameter  int unsigned SAMPLE_W = ssel_pkg::SSEL_SAMPLE_DEF,
  localparam int unsigned WORD_W   = LANES * SAMPLE_W,
  localparam int unsigned SEL_W    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [WORD_W-1:0] cur_o,
  output logic [WORD_W-1:0] prev_o,
  output logic [SEL_W-1:0]  sel_o
);

  logic [WORD_W-1:0] cur_q,  cur_d;
  logic [WORD_W-1:0] prev_q, prev_d;
  logic [SEL_W-1:0]  sel_q,  sel_d;
  logic              adv;

  // The stream advances one word every clock.
  assign adv = 1'b1;

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    sel_d  = sel_q;
    if (adv) begin
      cur_d  = din_i;
      prev_d = cur_q;
      sel_d  = sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      sel_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      sel_q  <= sel_d;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
  assign sel_o  = sel_q;

endmodule

// File: rtl/ssel_window_mux.sv
module ssel_window_mux #(
  parameter  int unsigned LANES    = ssel_pkg::SSEL_LANES_DEF,
  parameter  int unsigned SAMPLE_W = ssel_pkg::SSEL_SAMPLE_DEF,
  localparam int unsigned WORD_W   = LANES * SAMPLE_W,
  localparam int unsigned SEL_W    = $clog2(LANES),
  localparam int unsigned WIN_N    = 2 * LANES,
  localparam int unsigned IDX_W    = $clog2(WIN_N)
) (
  input  logic [WORD_W-1:0] cur_i,
  input  logic [WORD_W-1:0] prev_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [WORD_W-1:0] slice_o
);

  logic [SAMPLE_W-1:0] win [WIN_N];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_win
      assign win[i]         = prev_i[i*SAMPLE_W +: SAMPLE_W];
      assign win[LANES + i] = cur_i[i*SAMPLE_W +: SAMPLE_W];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [IDX_W-1:0] src;
      assign src = IDX_W'(ssel_pkg::window_src(LANES, k, int'(sel_i)));
      assign slice_o[k*SAMPLE_W +: SAMPLE_W] = win[src];
    end
  endgenerate

endmodule

// File: rtl/ssel_out_reg.sv
module ssel_out_reg #(
  parameter  int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o
);

  logic [WORD_W-1:0] q_q, q_d;
  logic              load;

  assign load = 1'b1;

  always_comb begin
    q_d = q_q;
    if (load) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/sample_shift_selector.sv
module sample_shift_selector #(
  parameter  int unsigned LANES    = ssel_pkg::SSEL_LANES_DEF,
  parameter  int unsigned SAMPLE_W = ssel_pkg::SSEL_SAMPLE_DEF,
  localparam int unsigned WORD_W   = LANES * SAMPLE_W,
  localparam int unsigned SEL_W    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din_i,
  input  logic [SEL_W-1:0]  shift_sel_i,
  output logic [WORD_W-1:0] dout_o
);

  logic [WORD_W-1:0] cur_w, prev_w, slice_w;
  logic [SEL_W-1:0]  sel_w;

  ssel_history #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (din_i),
    .sel_i  (shift_sel_i),
    .cur_o  (cur_w),
    .prev_o (prev_w),
    .sel_o  (sel_w)
  );

  ssel_window_mux #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_mux (
    .cur_i   (cur_w),
    .prev_i  (prev_w),
    .sel_i   (sel_w),
    .slice_o (slice_w)
  );

  ssel_out_reg #(.WORD_W(WORD_W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (slice_w),
    .q_o   (dout_o)
  );

  // Edges seen since reset release, saturating; only bounds the assertions.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q <= 2'd1) |-> (dout_o == '0));

  a_r3_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(shift_sel_i) == SEL_W'(0))
    |=> (dout_o == $past(din_i, 2)));

  a_r4_one_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(shift_sel_i) == SEL_W'(1))
    |=> (dout_o == {$past(din_i, 2) [WORD_W-SAMPLE_W-1:0],
                    $past(din_i, 3) [WORD_W-1 -: SAMPLE_W]}));

  generate
    if (LANES >= 3) begin : g_two_sample
      a_r5_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(shift_sel_i) == SEL_W'(2))
        |=> (dout_o == {$past(din_i, 2) [WORD_W-2*SAMPLE_W-1:0],
                        $past(din_i, 3) [WORD_W-1 -: 2*SAMPLE_W]}));
    end
  endgenerate

  a_r6_max_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(shift_sel_i) == SEL_W'(LANES-1))
    |=> (dout_o == {$past(din_i, 2) [SAMPLE_W-1:0],
                    $past(din_i, 3) [WORD_W-1:SAMPLE_W]}));

endmodule

// File: tb/sim_sample_shift_selector.sv
module sim_sample_shift_selector;

  localparam int LANES = 4;
  localparam int SW    = 8;
  localparam int WW    = LANES * SW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [WW-1:0] din;
  logic [1:0]    sel;
  logic [WW-1:0] dout;

  always #5 clk = ~clk;

  sample_shift_selector u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .din_i       (din),
    .shift_sel_i (sel),
    .dout_o      (dout)
  );

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  int    stream[$];
  int    sel_of[$];
  string tag_of[$];
  int    nwords = 0;

  // Expected output now: it covers word nwords-2 (R7), shifted by that word's select.
  function automatic logic [WW-1:0] expected();
    logic [WW-1:0] e = '0;
    if (nwords < 2) return '0;
    for (int k = 0; k < LANES; k++) begin
      int idx = LANES*(nwords-2) + k - sel_of[nwords-2];
      e[k*SW +: SW] = (idx < 0) ? 8'h00 : 8'(stream[idx]);
    end
    return e;
  endfunction

  task automatic check_now();
    logic [WW-1:0] e = expected();
    string t = (nwords < 2) ? "R1" : tag_of[nwords-2];
    n_vec++;
    if (dout !== e) begin
      n_bad++;
      $display("FAIL %s: dout=%h expected %h (word %0d)", t, dout, e, nwords-2);
    end
  endtask

  task automatic step(input logic [WW-1:0] w, input int s, input string t);
    @(negedge clk);
    check_now();
    din = w;
    sel = 2'(s);
    for (int k = 0; k < LANES; k++) stream.push_back(int'(w[k*SW +: SW]));
    sel_of.push_back(s);
    tag_of.push_back(t);
    nwords++;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    int seq[8];
    rst_n = 1'b0;
    din   = '1;
    sel   = 2'd3;
    // R1: output held at zero while in reset
    repeat (3) begin
      @(negedge clk);
      n_vec++;
      if (dout !== '0) begin
        n_bad++;
        $display("FAIL R1: dout=%h expected %h in reset", dout, {WW{1'b0}});
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    din   = '0;
    sel   = '0;

    // R2 / R7: ramp of lane-indexed bytes, one-sample shift crosses words
    for (int i = 0; i < 6; i++)
      step({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}, 1, "R2");
    // R3..R6: each fixed shift with random data
    for (int i = 0; i < 8; i++) step($urandom, 0, "R3");
    for (int i = 0; i < 8; i++) step($urandom, 1, "R4");
    for (int i = 0; i < 8; i++) step($urandom, 2, "R5");
    for (int i = 0; i < 8; i++) step($urandom, 3, "R6");
    // R8: select changes every word in a mixed order
    seq = '{0, 3, 1, 2, 3, 0, 2, 1};
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 8; i++) step($urandom, seq[i], "R8");
    for (int i = 0; i < 12; i++) step($urandom, $urandom_range(0, 3), "R8");
    // R9: long held shift on a counting ramp
    for (int i = 0; i < 16; i++)
      step({8'(4*i+203), 8'(4*i+202), 8'(4*i+201), 8'(4*i+200)}, 2, "R9");
    // flush the pipe so the last words are compared
    step('0, 0, "R9");
    step('0, 0, "R9");
    @(negedge clk);
    check_now();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, actual hung, expected finish");
      summary();
      $finish;
    end
  end

endmodule